// File: doc/BRIEF.md
# Working Register File with Address Pointer Pairs

This block holds the general working registers of a small 8-bit CPU core. Any two registers can be read at once as ALU operands, and either one 8-bit result or one 16-bit result written back in the same cycle. A 16-bit result goes to an aligned register pair. All reads are combinational, so an operand read and its write-back share one clock cycle.

The six highest registers also serve as three 16-bit address pointers. Each pointer keeps its low byte in the even register and its high byte in the odd one. A pointer port selects one of the three, produces an effective address, and can update the pointer. The update is either an increment after the access or a decrement before it, and the whole 16-bit value goes back in one cycle. The register file is also mapped into the lowest addresses of data space, so loads and stores whose address falls in that window reach the registers directly.

Top module: `regfile_ptr`

## Requirements
- R1: While `rst_ni` is low, every register is cleared to zero.
- R2: `rd_a_data_o` and `rd_b_data_o` show, in the same cycle, the registers named by `rd_a_idx_i` and `rd_b_idx_i`.
- R3: An 8-bit write (`wr8_en_i`) updates register `wr8_idx_i` at the next rising edge. A read of that register in the same cycle returns the old value.
- R4: A 16-bit write (`wr16_en_i`) to pair k puts `wr16_data_i[7:0]` into register 2k and `wr16_data_i[15:0]` bits 15:8 into register 2k+1, at the same edge.
- R5: `ptr_sel_i` values 0, 1 and 2 select the pointers in registers 26/27, 28/29 and 30/31 (low byte even, high byte odd). `ptr_val_o` shows the selected pointer. Value 3 selects nothing: `ptr_val_o` is zero and no register is updated.
- R6: `ptr_op_i` encoding: 0 gives `ptr_addr_o` = pointer with no update. 1 gives pointer + zero-extended `ptr_disp_i` with no update. 2 gives the pointer, and the pointer then becomes pointer+1. 3 gives pointer-1, and the pointer becomes pointer-1.
- R7: Pointer arithmetic is 16 bits wide and carries across the two bytes: 0x00FF+1 gives 0x0100, and 0x0000-1 gives 0xFFFF.
- R8: A data-space access (`ds_en_i`) with `ds_addr_i` below 32 raises `ds_hit_o`, and `ds_rdata_o` shows register `ds_addr_i`. Any other address gives `ds_hit_o`=0 and `ds_rdata_o`=0.
- R9: A data-space write (`ds_we_i` on a hit) updates that register at the next edge. On a miss it changes no register.
- R10: When several writes reach one register in one cycle, the winner is chosen in this order: 8-bit write, then 16-bit write, then pointer update, then data-space write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_idx_i | input | 5 | Operand A register index |
| rd_a_data_o | output | 8 | Operand A value |
| rd_b_idx_i | input | 5 | Operand B register index |
| rd_b_data_o | output | 8 | Operand B value |
| wr8_en_i | input | 1 | 8-bit write-back enable |
| wr8_idx_i | input | 5 | 8-bit write-back register |
| wr8_data_i | input | 8 | 8-bit write-back data |
| wr16_en_i | input | 1 | 16-bit write-back enable |
| wr16_pair_i | input | 4 | 16-bit write-back pair index |
| wr16_data_i | input | 16 | 16-bit write-back data |
| ptr_sel_i | input | 2 | Pointer select (3 = none) |
| ptr_op_i | input | 2 | Pointer operation |
| ptr_disp_i | input | 6 | Unsigned displacement |
| ptr_val_o | output | 16 | Selected pointer value |
| ptr_addr_o | output | 16 | Effective address |
| ds_en_i | input | 1 | Data-space access valid |
| ds_we_i | input | 1 | Data-space write |
| ds_addr_i | input | 16 | Data-space address |
| ds_wdata_i | input | 8 | Data-space write data |
| ds_hit_o | output | 1 | Access falls in register window |
| ds_rdata_o | output | 8 | Window read data |

## Verification
The bench targets pointer carries and borrows across the byte boundary. A design that updated each byte on its own would leave 0x00FF at 0x0000 after an increment, or 0x0000 at 0x00FF after a decrement. It also aims every writer at the same register in one cycle. A wrong priority order would let a data-space store or a pointer update overwrite a core write-back. It reads registers while they are being written; a bypass path would return the new value a cycle early. Stores just above the window are checked to leave the file untouched, which catches an off-by-one in the address compare.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  typedef enum logic [1:0] {
    PTR_NONE    = 2'd0,
    PTR_DISP    = 2'd1,
    PTR_POSTINC = 2'd2,
    PTR_PREDEC  = 2'd3
  } ptr_op_e;

  localparam int NUM_PTRS = 3;
endpackage

// File: rtl/rf_ptr_unit.sv
module rf_ptr_unit import regfile_pkg::*; #(
  parameter int AW     = 16,
  parameter int DISP_W = 6
) (
  input  logic [AW-1:0]     ptr_i,
  input  logic              valid_i,
  input  ptr_op_e           op_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [AW-1:0]     addr_o,
  output logic [AW-1:0]     next_o,
  output logic              upd_o
);
  logic [AW-1:0] inc_w, dec_w;
  assign inc_w = ptr_i + AW'(1);
  assign dec_w = ptr_i - AW'(1);

  always_comb begin
    addr_o = ptr_i;
    next_o = ptr_i;
    upd_o  = 1'b0;
    unique case (op_i)
      PTR_NONE:    addr_o = ptr_i;
      PTR_DISP:    addr_o = ptr_i + AW'(disp_i);
      PTR_POSTINC: begin
        next_o = inc_w;
        upd_o  = valid_i;
      end
      PTR_PREDEC: begin
        addr_o = dec_w;
        next_o = dec_w;
        upd_o  = valid_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rf_ds_window.sv
module rf_ds_window #(
  parameter int AW       = 16,
  parameter int NUM_REGS = 32,
  localparam int IW      = $clog2(NUM_REGS)
) (
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic          we_o,
  output logic [IW-1:0] idx_o
);
  assign hit_o = en_i && (addr_i < AW'(NUM_REGS));
  assign we_o  = hit_o && we_i;
  assign idx_o = addr_i[IW-1:0];
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int NUM_REGS = 32,
  parameter int DW       = 8,
  localparam int IW      = $clog2(NUM_REGS),
  localparam int PW      = IW - 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr8_en_i,
  input  logic [IW-1:0]                 wr8_idx_i,
  input  logic [DW-1:0]                 wr8_data_i,
  input  logic                          wr16_en_i,
  input  logic [PW-1:0]                 wr16_pair_i,
  input  logic [2*DW-1:0]               wr16_data_i,
  input  logic                          pupd_en_i,
  input  logic [PW-1:0]                 pupd_pair_i,
  input  logic [2*DW-1:0]               pupd_data_i,
  input  logic                          ds_we_i,
  input  logic [IW-1:0]                 ds_idx_i,
  input  logic [DW-1:0]                 ds_data_i,
  output logic [NUM_REGS-1:0][DW-1:0]   regs_o
);
  logic [NUM_REGS-1:0][DW-1:0] regs_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam int PAIR = i / 2;
    localparam bit HI   = (i % 2) == 1;
    logic          we;
    logic [DW-1:0] d;

    // priority: core 8b > core 16b > pointer update > data space
    always_comb begin
      we = 1'b1;
      if (wr8_en_i && wr8_idx_i == IW'(i))
        d = wr8_data_i;
      else if (wr16_en_i && wr16_pair_i == PW'(PAIR))
        d = HI ? wr16_data_i[2*DW-1:DW] : wr16_data_i[DW-1:0];
      else if (pupd_en_i && pupd_pair_i == PW'(PAIR))
        d = HI ? pupd_data_i[2*DW-1:DW] : pupd_data_i[DW-1:0];
      else if (ds_we_i && ds_idx_i == IW'(i))
        d = ds_data_i;
      else begin
        we = 1'b0;
        d  = regs_q[i];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  regs_q[i] <= '0;
      else if (we)  regs_q[i] <= d;
    end
  end

  assign regs_o = regs_q;

  AST_WR8_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr8_en_i |=> regs_q[$past(wr8_idx_i)] == $past(wr8_data_i)); // R3

  AST_WR16_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr16_en_i && !wr8_en_i) |=>
      {regs_q[{$past(wr16_pair_i), 1'b1}], regs_q[{$past(wr16_pair_i), 1'b0}]}
        == $past(wr16_data_i)); // R4

  AST_CORE_BEATS_DS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ds_we_i && wr8_en_i && wr8_idx_i == ds_idx_i) |=>
      regs_q[$past(ds_idx_i)] == $past(wr8_data_i)); // R10
endmodule

// File: rtl/regfile_ptr.sv
module regfile_ptr import regfile_pkg::*; #(
  parameter int NUM_REGS = 32,
  parameter int DW       = 8,
  parameter int DISP_W   = 6,
  localparam int AW      = 2 * DW,
  localparam int IW      = $clog2(NUM_REGS),
  localparam int PW      = IW - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IW-1:0]     rd_a_idx_i,
  output logic [DW-1:0]     rd_a_data_o,
  input  logic [IW-1:0]     rd_b_idx_i,
  output logic [DW-1:0]     rd_b_data_o,
  input  logic              wr8_en_i,
  input  logic [IW-1:0]     wr8_idx_i,
  input  logic [DW-1:0]     wr8_data_i,
  input  logic              wr16_en_i,
  input  logic [PW-1:0]     wr16_pair_i,
  input  logic [AW-1:0]     wr16_data_i,
  input  logic [1:0]        ptr_sel_i,
  input  logic [1:0]        ptr_op_i,
  input  logic [DISP_W-1:0] ptr_disp_i,
  output logic [AW-1:0]     ptr_val_o,
  output logic [AW-1:0]     ptr_addr_o,
  input  logic              ds_en_i,
  input  logic              ds_we_i,
  input  logic [AW-1:0]     ds_addr_i,
  input  logic [DW-1:0]     ds_wdata_i,
  output logic              ds_hit_o,
  output logic [DW-1:0]     ds_rdata_o
);
  localparam int FIRST_PTR_PAIR = NUM_REGS / 2 - NUM_PTRS;

  logic [NUM_REGS-1:0][DW-1:0] regs_w;
  logic                        ptr_valid_w, ptr_upd_w, ds_we_w;
  logic [PW-1:0]               ptr_pair_w;
  logic [IW-1:0]               ptr_lo_w, ptr_hi_w, ds_idx_w;
  logic [AW-1:0]               ptr_next_w;

  assign ptr_valid_w = ptr_sel_i < 2'(NUM_PTRS);
  assign ptr_pair_w  = PW'(FIRST_PTR_PAIR) + PW'(ptr_sel_i);
  assign ptr_lo_w    = {ptr_pair_w, 1'b0};
  assign ptr_hi_w    = {ptr_pair_w, 1'b1};
  assign ptr_val_o   = ptr_valid_w ? {regs_w[ptr_hi_w], regs_w[ptr_lo_w]} : '0;

  rf_ptr_unit #(.AW(AW), .DISP_W(DISP_W)) u_ptr (
    .ptr_i   (ptr_val_o),
    .valid_i (ptr_valid_w),
    .op_i    (ptr_op_e'(ptr_op_i)),
    .disp_i  (ptr_disp_i),
    .addr_o  (ptr_addr_o),
    .next_o  (ptr_next_w),
    .upd_o   (ptr_upd_w)
  );

  rf_ds_window #(.AW(AW), .NUM_REGS(NUM_REGS)) u_win (
    .en_i   (ds_en_i),
    .we_i   (ds_we_i),
    .addr_i (ds_addr_i),
    .hit_o  (ds_hit_o),
    .we_o   (ds_we_w),
    .idx_o  (ds_idx_w)
  );

  rf_storage #(.NUM_REGS(NUM_REGS), .DW(DW)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr8_en_i    (wr8_en_i),
    .wr8_idx_i   (wr8_idx_i),
    .wr8_data_i  (wr8_data_i),
    .wr16_en_i   (wr16_en_i),
    .wr16_pair_i (wr16_pair_i),
    .wr16_data_i (wr16_data_i),
    .pupd_en_i   (ptr_upd_w),
    .pupd_pair_i (ptr_pair_w),
    .pupd_data_i (ptr_next_w),
    .ds_we_i     (ds_we_w),
    .ds_idx_i    (ds_idx_w),
    .ds_data_i   (ds_wdata_i),
    .regs_o      (regs_w)
  );

  assign rd_a_data_o = regs_w[rd_a_idx_i];
  assign rd_b_data_o = regs_w[rd_b_idx_i];
  assign ds_rdata_o  = ds_hit_o ? regs_w[ds_idx_w] : '0;

  AST_PTR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_upd_w && !wr8_en_i && !wr16_en_i) |=>
      {regs_w[$past(ptr_hi_w)], regs_w[$past(ptr_lo_w)]} == $past(ptr_next_w)); // R6

  AST_NO_PTR_UPD_UNSEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_valid_w && !wr8_en_i && !wr16_en_i && !(ds_en_i && ds_we_i)) |=>
      $stable(regs_w)); // R5

  AST_DS_MISS_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ds_en_i && ds_we_i && !ds_hit_o && !wr8_en_i && !wr16_en_i && !ptr_upd_w) |=>
      $stable(regs_w)); // R9

  AST_DS_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ds_addr_i >= AW'(NUM_REGS)) |-> (!ds_hit_o && ds_rdata_o == '0)); // R8
endmodule

// File: tb/tb_regfile_ptr.sv
module tb_regfile_ptr;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  rd_a_idx_i = '0, rd_b_idx_i = '0, wr8_idx_i = '0;
  logic [7:0]  rd_a_data_o, rd_b_data_o, wr8_data_i = '0, ds_wdata_i = '0, ds_rdata_o;
  logic        wr8_en_i = 1'b0, wr16_en_i = 1'b0, ds_en_i = 1'b0, ds_we_i = 1'b0, ds_hit_o;
  logic [3:0]  wr16_pair_i = '0;
  logic [15:0] wr16_data_i = '0, ptr_val_o, ptr_addr_o, ds_addr_i = '0;
  logic [1:0]  ptr_sel_i = 2'd3, ptr_op_i = '0;
  logic [5:0]  ptr_disp_i = '0;

  int n_vec = 0, n_err = 0;
  logic [7:0] m [32];

  regfile_ptr dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_ptr();
    if (ptr_sel_i == 2'd3) return 16'h0;
    return {m[27 + 2*ptr_sel_i], m[26 + 2*ptr_sel_i]};
  endfunction

  function automatic logic [15:0] exp_addr();
    logic [15:0] p = exp_ptr();
    case (ptr_op_i)
      2'd1:    return p + {10'd0, ptr_disp_i};
      2'd3:    return p - 16'd1;
      default: return p;
    endcase
  endfunction

  // compare outputs against model, then advance model (lowest priority first)
  task automatic check_and_step();
    logic [15:0] p;
    chk("R2", "rd_a", {8'h0, rd_a_data_o}, {8'h0, m[rd_a_idx_i]});
    chk("R2", "rd_b", {8'h0, rd_b_data_o}, {8'h0, m[rd_b_idx_i]});
    chk("R5", "ptr_val", ptr_val_o, exp_ptr());
    chk("R6", "ptr_addr", ptr_addr_o, exp_addr());
    chk("R8", "ds_hit", {15'h0, ds_hit_o}, {15'h0, ds_en_i && ds_addr_i < 16'd32});
    chk("R8", "ds_rdata", {8'h0, ds_rdata_o},
        (ds_en_i && ds_addr_i < 16'd32) ? {8'h0, m[ds_addr_i[4:0]]} : 16'h0);
    p = exp_ptr();
    if (ds_en_i && ds_we_i && ds_addr_i < 16'd32) m[ds_addr_i[4:0]] = ds_wdata_i;
    if (ptr_sel_i != 2'd3 && ptr_op_i[1]) begin
      p = ptr_op_i[0] ? p - 16'd1 : p + 16'd1;
      m[26 + 2*ptr_sel_i] = p[7:0];
      m[27 + 2*ptr_sel_i] = p[15:8];
    end
    if (wr16_en_i) begin
      m[2*wr16_pair_i]     = wr16_data_i[7:0];
      m[2*wr16_pair_i + 1] = wr16_data_i[15:8];
    end
    if (wr8_en_i) m[wr8_idx_i] = wr8_data_i;
  endtask

  task automatic idle();
    wr8_en_i = 0; wr16_en_i = 0; ds_en_i = 0; ds_we_i = 0;
    ptr_sel_i = 2'd3; ptr_op_i = 2'd0;
  endtask

  task automatic cyc();
    #2 check_and_step();
    @(negedge clk_i);
  endtask

  task automatic set_ptr(int s, logic [15:0] v);
    idle(); wr16_en_i = 1; wr16_pair_i = 4'(13 + s); wr16_data_i = v; cyc();
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) m[i] = 8'h0;
    repeat (2) @(negedge clk_i);
    for (int i = 0; i < 32; i++) begin
      rd_a_idx_i = 5'(i); #1;
      chk("R1", "reset value", {8'h0, rd_a_data_o}, 16'h0);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3: read of a register under write returns old value, new one next cycle
    idle(); wr8_en_i = 1; wr8_idx_i = 5'd7; wr8_data_i = 8'hA5; rd_a_idx_i = 5'd7; rd_b_idx_i = 5'd7;
    cyc();
    idle(); #1 chk("R3", "write landed", {8'h0, rd_a_data_o}, 16'h00A5);

    // R4 pair write
    idle(); wr16_en_i = 1; wr16_pair_i = 4'd2; wr16_data_i = 16'hBEEF; cyc();
    idle(); rd_a_idx_i = 5'd4; rd_b_idx_i = 5'd5; #1;
    chk("R4", "pair low", {8'h0, rd_a_data_o}, 16'h00EF);
    chk("R4", "pair high", {8'h0, rd_b_data_o}, 16'h00BE);

    // R7 carry and borrow across bytes, R6 post-inc / pre-dec
    set_ptr(0, 16'h00FF);
    idle(); ptr_sel_i = 2'd0; ptr_op_i = 2'd2; cyc();
    idle(); ptr_sel_i = 2'd0; #1 chk("R7", "inc carry", ptr_val_o, 16'h0100);
    set_ptr(1, 16'h0000);
    idle(); ptr_sel_i = 2'd1; ptr_op_i = 2'd3; cyc();
    idle(); ptr_sel_i = 2'd1; #1 chk("R7", "dec borrow", ptr_val_o, 16'hFFFF);
    set_ptr(2, 16'h1234);
    idle(); ptr_sel_i = 2'd2; ptr_op_i = 2'd1; ptr_disp_i = 6'd63; cyc();
    idle(); ptr_sel_i = 2'd2; #1 chk("R6", "disp no update", ptr_val_o, 16'h1234);

    // R10 all writers on register 30 (Z low)
    idle(); wr8_en_i = 1; wr8_idx_i = 5'd30; wr8_data_i = 8'h11;
    wr16_en_i = 1; wr16_pair_i = 4'd15; wr16_data_i = 16'h2222;
    ptr_sel_i = 2'd2; ptr_op_i = 2'd2; ds_en_i = 1; ds_we_i = 1; ds_addr_i = 16'd30; ds_wdata_i = 8'h33;
    cyc();
    idle(); rd_a_idx_i = 5'd30; rd_b_idx_i = 5'd31; #1;
    chk("R10", "8b wins", {8'h0, rd_a_data_o}, 16'h0011);
    chk("R10", "16b beats ptr", {8'h0, rd_b_data_o}, 16'h0022);
    idle(); ptr_sel_i = 2'd2; ptr_op_i = 2'd3; ds_en_i = 1; ds_we_i = 1; ds_addr_i = 16'd31; ds_wdata_i = 8'h77;
    cyc();
    idle(); ptr_sel_i = 2'd2; #1 chk("R10", "ptr beats ds", ptr_val_o, 16'h2210);

    // R9 write just past window is ignored; R5 unselected pointer
    idle(); ds_en_i = 1; ds_we_i = 1; ds_addr_i = 16'd32; ds_wdata_i = 8'h5A; ptr_sel_i = 2'd3; ptr_op_i = 2'd2;
    cyc();
    idle(); ds_en_i = 1; ds_addr_i = 16'd0; #1 chk("R9", "miss no write", {8'h0, ds_rdata_o}, {8'h0, m[0]});
    ds_we_i = 1; ds_wdata_i = 8'hC3; cyc();
    idle(); rd_a_idx_i = 5'd0; #1 chk("R9", "hit write", {8'h0, rd_a_data_o}, 16'h00C3);

    // constrained random mix
    for (int k = 0; k < 3000; k++) begin
      rd_a_idx_i  = 5'($urandom); rd_b_idx_i = 5'($urandom);
      wr8_en_i    = ($urandom % 4) == 0; wr8_idx_i = 5'($urandom); wr8_data_i = 8'($urandom);
      wr16_en_i   = ($urandom % 5) == 0; wr16_pair_i = 4'($urandom); wr16_data_i = 16'($urandom);
      ptr_sel_i   = 2'($urandom); ptr_op_i = 2'($urandom); ptr_disp_i = 6'($urandom);
      ds_en_i     = ($urandom % 2) == 0; ds_we_i = 1'($urandom);
      ds_addr_i   = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 40);
      ds_wdata_i  = 8'($urandom);
      cyc();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule